// File: doc/BRIEF.md
# Power-Management Event Status and Wake Controller

This block holds a 16-bit event status register together with its enable register and a small control register, and it decides what those bits do to the system. Hardware event inputs (a periodic timer, a global-lock release, a power button and an alarm) set status bits. Software reads the bits over a plain register port and clears them by writing ones. While the system sleeps, an enabled button or alarm event, or an active PCI Express wake level, raises a wake request. The controller then returns to the running state and records why it woke.

In the running state the same enabled status bits drive one of two level interrupts. A control bit routes them to the SCI output when set and to the SMI output when clear. The block tracks three power states (running, sleeping, soft-off). It models a power failure with a power-good input. The state it returns to after a power loss depends on a policy bit held in the always-on resume domain. The status and enable bits are split across two reset domains: the core domain is cleared by a hard reset or power loss, and the resume domain is cleared only by the resume-well reset.

Top module: `pm_evt_status`

## Requirements
- R1: After the resume reset, the status (address 0), enable (address 1) and control (address 2) registers read 0000h, `pwr_state` is 0 (running), and `sci`, `smi` and `wake_req` are low.
- R2: An event input pulse sets its status bit: timer bit 0, global-lock bit 5, button bit 8, alarm bit 10. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R3: Unimplemented bits read 0 and ignore writes. In status these are all bits except 0, 5, 8, 10, 14 and 15. In enable they are all bits except 0, 5, 8 and 10. In control they are all bits except 0 (interrupt route, 1 = SCI) and 2 (power-loss policy). Control bit 1 starts sleep when written with 1 and reads 0.
- R4: In the running state, a set status bit 0, 8 or 10 whose enable is set drives `sci` when control bit 0 is 1, and drives `smi` when it is 0. The level holds until the bit is cleared.
- R5: Status bit 5 with its enable set can drive `sci`. It never drives `smi` and never raises `wake_req`.
- R6: Status bit 0 with its enable set never raises `wake_req`.
- R7: Writing control bit 1 in the running state enters sleep (`pwr_state` 1). An enabled button or alarm status bit raises `wake_req`. On the next clock edge the state becomes running and status bit 15 is set. `sci` and `smi` stay low whenever the state is not running.
- R8: In a sleep or soft-off state, an active `pcie_wake_lvl` or `pme_pend_lvl` wakes the system and sets status bits 14 and 15. In the running state these levels set nothing.
- R9: A write of 1 to status bit 14 has no effect while `pcie_wake_lvl` or `pme_pend_lvl` is active.
- R10: A hard reset (`core_rst_n` low) clears status bits 0 and 5, enable bits 0 and 5, and control bit 0. It keeps status bits 8, 10, 14 and 15, enable bits 8 and 10, and control bit 2.
- R11: When `pwr_good` drops while running and returns with the policy bit at 0, the state is running on the first edge after the return and status bit 15 stays clear.
- R12: With the policy bit at 1, the same power loss leaves the system in soft-off (`pwr_state` 2). A preserved enabled alarm or button event then wakes it and sets bit 15.
- R13: A set status bit 14 does not prevent sleep entry and does not wake the system on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rsm_rst_n | input | 1 | Resume-well reset, asynchronous, active low, clears everything |
| core_rst_n | input | 1 | Hard reset, synchronous, active low, clears core-domain bits |
| pwr_good | input | 1 | Main power present; low models a power failure |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | 0 status, 1 enable, 2 control |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| ev_timer | input | 1 | Timer overflow event |
| ev_lock | input | 1 | Global-lock release event |
| ev_button | input | 1 | Power button event |
| ev_alarm | input | 1 | Alarm event |
| pcie_wake_lvl | input | 1 | PCI Express wake pin level, active high |
| pme_pend_lvl | input | 1 | Root-port PME pending level, active high |
| wake_req | output | 1 | Wake request while not running |
| sci | output | 1 | SCI level |
| smi | output | 1 | SMI level |
| pwr_state | output | 2 | 0 running, 1 sleeping, 2 soft-off |

## Verification
The routing logic is tried one source at a time (timer, global lock, button, alarm) under both route settings. This separates which bits may reach SMI from which may reach only SCI. Sleep is tried with a non-waking enabled source first and a waking one second, so a design that wakes on any enabled bit is caught. The PCI Express levels are applied in the running state, during sleep, and across a clear attempt, which separates a transition-triggered set from a level-held one. Hard reset and power loss are each applied with bits set in both domains and with both policy settings, so a bit placed in the wrong domain or a wrong return state shows up.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;

  localparam int REG_W   = 16;
  localparam int ADDR_W  = 2;

  localparam int B_TMR   = 0;
  localparam int B_LOCK  = 5;
  localparam int B_BTN   = 8;
  localparam int B_ALM   = 10;
  localparam int B_PCIE  = 14;
  localparam int B_WAK   = 15;

  localparam int C_ROUTE = 0;
  localparam int C_SLEEP = 1;
  localparam int C_POL   = 2;

  localparam logic [REG_W-1:0] M_TMR  = REG_W'(1) << B_TMR;
  localparam logic [REG_W-1:0] M_LOCK = REG_W'(1) << B_LOCK;
  localparam logic [REG_W-1:0] M_BTN  = REG_W'(1) << B_BTN;
  localparam logic [REG_W-1:0] M_ALM  = REG_W'(1) << B_ALM;
  localparam logic [REG_W-1:0] M_PCIE = REG_W'(1) << B_PCIE;
  localparam logic [REG_W-1:0] M_WAK  = REG_W'(1) << B_WAK;

  // implemented bits and the subset living in the resume domain
  localparam logic [REG_W-1:0] STS_IMPL = M_TMR | M_LOCK | M_BTN | M_ALM | M_PCIE | M_WAK;
  localparam logic [REG_W-1:0] STS_RSM  = M_BTN | M_ALM | M_PCIE | M_WAK;
  localparam logic [REG_W-1:0] EN_IMPL  = M_TMR | M_LOCK | M_BTN | M_ALM;
  localparam logic [REG_W-1:0] EN_RSM   = M_BTN | M_ALM;

  // which enabled sources may reach each consumer
  localparam logic [REG_W-1:0] SCI_OK  = M_TMR | M_LOCK | M_BTN | M_ALM;
  localparam logic [REG_W-1:0] SMI_OK  = M_TMR | M_BTN | M_ALM;
  localparam logic [REG_W-1:0] WAKE_OK = M_BTN | M_ALM;

  typedef enum logic [1:0] {
    PS_RUN   = 2'd0,
    PS_SLEEP = 2'd1,
    PS_OFF   = 2'd2
  } pstate_e;

  typedef enum logic [ADDR_W-1:0] {
    A_STS = 2'd0,
    A_EN  = 2'd1,
    A_CTL = 2'd2
  } raddr_e;

  function automatic logic [REG_W-1:0] armed(input logic [REG_W-1:0] sts,
                                             input logic [REG_W-1:0] en,
                                             input logic [REG_W-1:0] ok);
    return sts & en & ok;
  endfunction

  // set wins; a clear request is refused while a level input holds the bit
  function automatic logic bit_next(input logic q, input logic set,
                                    input logic clr, input logic hold);
    return set | (q & ~(clr & ~hold));
  endfunction

endpackage

// File: rtl/pm_status_bits.sv
module pm_status_bits
  import pm_evt_pkg::*;
#(
  parameter int                W        = REG_W,
  parameter logic [REG_W-1:0]  S_IMPL   = STS_IMPL,
  parameter logic [REG_W-1:0]  S_RSM    = STS_RSM,
  parameter logic [REG_W-1:0]  E_IMPL   = EN_IMPL,
  parameter logic [REG_W-1:0]  E_RSM    = EN_RSM
) (
  input  logic         clk,
  input  logic         rsm_rst_n,
  input  logic         core_clr,
  input  logic         wr_sts,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] hold_vec,
  output logic [W-1:0] sts_q,
  output logic [W-1:0] en_q
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (S_IMPL[i]) begin : g_sts
      logic q;
      always_ff @(posedge clk or negedge rsm_rst_n) begin
        if (!rsm_rst_n)
          q <= 1'b0;
        else if (core_clr && !S_RSM[i])
          q <= 1'b0;
        else
          q <= bit_next(q, set_vec[i], wr_sts & wdata[i], hold_vec[i]);
      end
      assign sts_q[i] = q;
    end else begin : g_sts_none
      assign sts_q[i] = 1'b0;
    end

    if (E_IMPL[i]) begin : g_en
      logic q;
      always_ff @(posedge clk or negedge rsm_rst_n) begin
        if (!rsm_rst_n)
          q <= 1'b0;
        else if (core_clr && !E_RSM[i])
          q <= 1'b0;
        else if (wr_en)
          q <= wdata[i];
      end
      assign en_q[i] = q;
    end else begin : g_en_none
      assign en_q[i] = 1'b0;
    end
  end

endmodule

// File: rtl/pm_power_fsm.sv
module pm_power_fsm
  import pm_evt_pkg::*;
(
  input  logic    clk,
  input  logic    rsm_rst_n,
  input  logic    pwr_good,
  input  logic    sleep_go,
  input  logic    policy_off,
  input  logic    wake_hit,
  output pstate_e state,
  output logic    wake_now,
  output logic    pg_stable
);

  logic pg_q;

  assign pg_stable = pwr_good & pg_q;
  assign wake_now  = pg_stable & (state != PS_RUN) & wake_hit;

  // state the machine takes when main power comes back
  function automatic pstate_e on_return(input pstate_e s, input logic pol);
    if (s == PS_RUN) return pol ? PS_OFF : PS_RUN;
    return s;
  endfunction

  always_ff @(posedge clk or negedge rsm_rst_n) begin
    if (!rsm_rst_n) begin
      state <= PS_RUN;
      pg_q  <= 1'b0;
    end else begin
      pg_q <= pwr_good;
      if (pwr_good) begin
        if (!pg_q)
          state <= on_return(state, policy_off);
        else if (wake_now)
          state <= PS_RUN;
        else if (state == PS_RUN && sleep_go)
          state <= PS_SLEEP;
      end
    end
  end

endmodule

// File: rtl/pm_irq_route.sv
module pm_irq_route
  import pm_evt_pkg::*;
(
  input  logic [REG_W-1:0] sts,
  input  logic [REG_W-1:0] en,
  input  logic             route_sci,
  input  pstate_e          state,
  output logic             sci,
  output logic             smi
);

  logic running;
  assign running = (state == PS_RUN);
  assign sci = running &  route_sci & (|armed(sts, en, SCI_OK));
  assign smi = running & ~route_sci & (|armed(sts, en, SMI_OK));

endmodule

// File: rtl/pm_evt_status.sv
module pm_evt_status
  import pm_evt_pkg::*;
(
  input  logic              clk,
  input  logic              rsm_rst_n,
  input  logic              core_rst_n,
  input  logic              pwr_good,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              ev_timer,
  input  logic              ev_lock,
  input  logic              ev_button,
  input  logic              ev_alarm,
  input  logic              pcie_wake_lvl,
  input  logic              pme_pend_lvl,
  output logic              wake_req,
  output logic              sci,
  output logic              smi,
  output logic [1:0]        pwr_state
);

  logic             core_clr, wr_ok, wr_sts, wr_en, wr_ctl, sleep_go;
  logic             route_sci_q, policy_q;
  logic             pcie_src, wake_hit, wake_now, pg_stable;
  logic [REG_W-1:0] status_q, enable_q, set_vec, hold_vec, ctl_view;
  pstate_e          state;

  assign core_clr = ~core_rst_n | ~pwr_good;
  assign wr_ok    = reg_wr & ~core_clr;
  assign wr_sts   = wr_ok & (reg_addr == A_STS);
  assign wr_en    = wr_ok & (reg_addr == A_EN);
  assign wr_ctl   = wr_ok & (reg_addr == A_CTL);
  assign sleep_go = wr_ctl & reg_wdata[C_SLEEP];

  assign pcie_src = pcie_wake_lvl | pme_pend_lvl;
  assign wake_hit = (|armed(status_q, enable_q, WAKE_OK)) | pcie_src;

  always_comb begin
    set_vec         = '0;
    set_vec[B_TMR]  = ev_timer;
    set_vec[B_LOCK] = ev_lock;
    set_vec[B_BTN]  = ev_button;
    set_vec[B_ALM]  = ev_alarm;
    set_vec[B_PCIE] = wake_now & pcie_src;
    set_vec[B_WAK]  = wake_now;
  end

  always_comb begin
    hold_vec         = '0;
    hold_vec[B_PCIE] = pcie_src;
  end

  pm_status_bits u_bits (
    .clk      (clk),
    .rsm_rst_n(rsm_rst_n),
    .core_clr (core_clr),
    .wr_sts   (wr_sts),
    .wr_en    (wr_en),
    .wdata    (reg_wdata),
    .set_vec  (set_vec),
    .hold_vec (hold_vec),
    .sts_q    (status_q),
    .en_q     (enable_q)
  );

  // route bit: core domain; policy bit: resume domain
  always_ff @(posedge clk or negedge rsm_rst_n) begin
    if (!rsm_rst_n) begin
      route_sci_q <= 1'b0;
      policy_q    <= 1'b0;
    end else begin
      if (core_clr)
        route_sci_q <= 1'b0;
      else if (wr_ctl)
        route_sci_q <= reg_wdata[C_ROUTE];
      if (wr_ctl)
        policy_q <= reg_wdata[C_POL];
    end
  end

  pm_power_fsm u_fsm (
    .clk       (clk),
    .rsm_rst_n (rsm_rst_n),
    .pwr_good  (pwr_good),
    .sleep_go  (sleep_go),
    .policy_off(policy_q),
    .wake_hit  (wake_hit),
    .state     (state),
    .wake_now  (wake_now),
    .pg_stable (pg_stable)
  );

  pm_irq_route u_route (
    .sts      (status_q),
    .en       (enable_q),
    .route_sci(route_sci_q),
    .state    (state),
    .sci      (sci),
    .smi      (smi)
  );

  always_comb begin
    ctl_view          = '0;
    ctl_view[C_ROUTE] = route_sci_q;
    ctl_view[C_POL]   = policy_q;
  end

  always_comb begin
    unique case (reg_addr)
      A_STS:   reg_rdata = status_q;
      A_EN:    reg_rdata = enable_q;
      A_CTL:   reg_rdata = ctl_view;
      default: reg_rdata = '0;
    endcase
  end

  assign wake_req  = wake_now;
  assign pwr_state = state;

endmodule

// File: rtl/pm_evt_checker.sv
module pm_evt_checker
  import pm_evt_pkg::*;
(
  input logic             clk,
  input logic             rsm_rst_n,
  input logic             core_rst_n,
  input logic             pcie_wake_lvl,
  input logic             pme_pend_lvl,
  input logic             wake_req,
  input logic             sci,
  input logic             smi,
  input logic [1:0]       pwr_state,
  input logic [REG_W-1:0] status_q
);

  assert_route_exclusive_R4: assert property (@(posedge clk) disable iff (!rsm_rst_n)
    !(sci && smi));

  assert_quiet_asleep_R7: assert property (@(posedge clk) disable iff (!rsm_rst_n)
    (pwr_state != PS_RUN) |-> (!sci && !smi));

  assert_wake_lands_R7: assert property (@(posedge clk) disable iff (!rsm_rst_n)
    wake_req |=> (pwr_state == PS_RUN && status_q[B_WAK]));

  assert_level_hold_R9: assert property (@(posedge clk) disable iff (!rsm_rst_n)
    (status_q[B_PCIE] && (pcie_wake_lvl || pme_pend_lvl)) |=> status_q[B_PCIE]);

  assert_wak_survives_R10: assert property (@(posedge clk) disable iff (!rsm_rst_n)
    (!core_rst_n && status_q[B_WAK]) |=> status_q[B_WAK]);

  assert_off_no_sleep_R12: assert property (@(posedge clk) disable iff (!rsm_rst_n)
    (pwr_state == PS_OFF) |=> (pwr_state != PS_SLEEP));

endmodule

bind pm_evt_status pm_evt_checker u_chk (
  .clk          (clk),
  .rsm_rst_n    (rsm_rst_n),
  .core_rst_n   (core_rst_n),
  .pcie_wake_lvl(pcie_wake_lvl),
  .pme_pend_lvl (pme_pend_lvl),
  .wake_req     (wake_req),
  .sci          (sci),
  .smi          (smi),
  .pwr_state    (pwr_state),
  .status_q     (status_q)
);

// File: tb/pm_evt_status_test.sv
module pm_evt_status_test;

  logic        clk = 1'b0;
  logic        rsm_rst_n = 1'b0, core_rst_n = 1'b1, pwr_good = 1'b1;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = 16'h0, reg_rdata;
  logic        ev_timer = 0, ev_lock = 0, ev_button = 0, ev_alarm = 0;
  logic        pcie_wake_lvl = 0, pme_pend_lvl = 0;
  logic        wake_req, sci, smi;
  logic [1:0]  pwr_state;
  int          n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  pm_evt_status uut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] a, input logic [15:0] exp);
    reg_addr = a; #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which) 0: ev_timer = 1; 5: ev_lock = 1; 8: ev_button = 1; default: ev_alarm = 1; endcase
    @(negedge clk);
    ev_timer = 0; ev_lock = 0; ev_button = 0; ev_alarm = 0;
  endtask

  task automatic cleanup();
    wr(2'd0, 16'hFFFF); wr(2'd1, 16'h0000); wr(2'd2, 16'h0000);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rsm_rst_n = 1'b1;
    @(negedge clk);
    rd_chk("R1 status", 2'd0, 16'h0000);
    rd_chk("R1 enable", 2'd1, 16'h0000);
    rd_chk("R1 control", 2'd2, 16'h0000);
    chk("R1 state", pwr_state, 2'd0);
    chk("R1 sci/smi/wake", {sci, smi, wake_req}, 3'b000);
  endtask

  task automatic t_w1c();
    pulse(0); pulse(5); pulse(8); pulse(10);
    rd_chk("R2 all events", 2'd0, 16'h0521);
    wr(2'd0, 16'h0000);
    rd_chk("R2 write zero keeps", 2'd0, 16'h0521);
    wr(2'd0, 16'h0001);
    rd_chk("R2 clear bit0 only", 2'd0, 16'h0520);
    wr(2'd0, 16'h0520);
    rd_chk("R2 clear rest", 2'd0, 16'h0000);
  endtask

  task automatic t_unimpl();
    wr(2'd1, 16'hFFFF);
    rd_chk("R3 enable mask", 2'd1, 16'h0521);
    wr(2'd1, 16'h0000);
    pulse(8);
    wr(2'd0, 16'h3EFF);
    rd_chk("R3 status unimpl writes", 2'd0, 16'h0100);
    wr(2'd2, 16'hFFF9);
    rd_chk("R3 control mask", 2'd2, 16'h0001);
    chk("R3 no sleep", pwr_state, 2'd0);
    cleanup();
  endtask

  task automatic t_route();
    wr(2'd1, 16'h0101);
    pulse(8);
    chk("R4 button smi", {sci, smi}, 2'b01);
    wr(2'd2, 16'h0001);
    chk("R4 button sci", {sci, smi}, 2'b10);
    wr(2'd0, 16'h0100);
    chk("R4 cleared", {sci, smi}, 2'b00);
    pulse(0);
    chk("R4 timer sci", {sci, smi}, 2'b10);
    wr(2'd2, 16'h0000);
    chk("R4 timer smi", {sci, smi}, 2'b01);
    wr(2'd0, 16'h0001);
    chk("R4 timer cleared", {sci, smi}, 2'b00);
    wr(2'd1, 16'h0400); pulse(10);
    chk("R4 alarm smi", {sci, smi}, 2'b01);
    cleanup();
  endtask

  task automatic t_bit5_bit0();
    wr(2'd1, 16'h0020);
    pulse(5);
    chk("R5 lock no smi", {sci, smi}, 2'b00);
    wr(2'd2, 16'h0001);
    chk("R5 lock sci", {sci, smi}, 2'b10);
    wr(2'd1, 16'h0021);
    pulse(0);
    wr(2'd2, 16'h0002);
    chk("R7 asleep", pwr_state, 2'd1);
    repeat (4) @(negedge clk);
    chk("R5 R6 no wake", {wake_req, pwr_state}, 3'b001);
    chk("R7 quiet asleep", {sci, smi}, 2'b00);
    wr(2'd1, 16'h0121);
    pulse(8);
    chk("R7 wake req", wake_req, 1'b1);
    @(negedge clk);
    chk("R7 running", pwr_state, 2'd0);
    rd_chk("R7 wake status", 2'd0, 16'h8121);
    chk("R4 smi after wake", {sci, smi}, 2'b01);
    cleanup();
  endtask

  task automatic t_alarm_wake();
    wr(2'd1, 16'h0400);
    wr(2'd2, 16'h0003);
    chk("R7 sleep", pwr_state, 2'd1);
    @(negedge clk); ev_alarm = 1;
    @(negedge clk); ev_alarm = 0;
    chk("R7 alarm wake req", {wake_req, pwr_state}, 3'b101);
    chk("R7 no sci asleep", sci, 1'b0);
    @(negedge clk);
    chk("R7 alarm running", pwr_state, 2'd0);
    rd_chk("R7 alarm status", 2'd0, 16'h8400);
    chk("R4 sci after wake", sci, 1'b1);
    cleanup();
  endtask

  task automatic t_pcie();
    pcie_wake_lvl = 1;
    repeat (3) @(negedge clk);
    chk("R8 no wake in run", wake_req, 1'b0);
    rd_chk("R8 no set in run", 2'd0, 16'h0000);
    pcie_wake_lvl = 0;
    wr(2'd2, 16'h0002);
    chk("R8 sleep", pwr_state, 2'd1);
    pme_pend_lvl = 1;
    @(negedge clk);
    chk("R8 pme running", pwr_state, 2'd0);
    rd_chk("R8 pme status", 2'd0, 16'hC000);
    wr(2'd0, 16'h4000);
    rd_chk("R9 held by level", 2'd0, 16'hC000);
    pme_pend_lvl = 0;
    wr(2'd2, 16'h0002);
    repeat (5) @(negedge clk);
    chk("R13 stays asleep", {wake_req, pwr_state}, 3'b001);
    wr(2'd1, 16'h0100);
    pulse(8);
    @(negedge clk);
    chk("R13 button wake", pwr_state, 2'd0);
    wr(2'd0, 16'h4000);
    rd_chk("R9 cleared after release", 2'd0, 16'h8100);
    cleanup();
  endtask

  task automatic t_core_reset();
    wr(2'd1, 16'h0121);
    wr(2'd2, 16'h0006);
    pulse(8);
    @(negedge clk);
    pulse(0); pulse(5);
    rd_chk("R10 setup", 2'd0, 16'h8121);
    wr(2'd2, 16'h0005);
    @(negedge clk); core_rst_n = 0;
    repeat (3) @(negedge clk);
    core_rst_n = 1;
    @(negedge clk);
    rd_chk("R10 status kept", 2'd0, 16'h8100);
    rd_chk("R10 enable kept", 2'd1, 16'h0100);
    rd_chk("R10 control kept", 2'd2, 16'h0004);
    chk("R10 state", pwr_state, 2'd0);
    cleanup();
  endtask

  task automatic t_pf_policy0();
    @(negedge clk); pwr_good = 0;
    repeat (3) @(negedge clk);
    pwr_good = 1;
    @(negedge clk);
    chk("R11 state run", pwr_state, 2'd0);
    rd_chk("R11 wak clear", 2'd0, 16'h0000);
  endtask

  task automatic t_pf_policy1();
    wr(2'd1, 16'h0400);
    wr(2'd2, 16'h0005);
    @(negedge clk); pwr_good = 0;
    repeat (3) @(negedge clk);
    pwr_good = 1;
    @(negedge clk);
    chk("R12 soft-off", pwr_state, 2'd2);
    rd_chk("R12 status", 2'd0, 16'h0000);
    rd_chk("R12 enable kept", 2'd1, 16'h0400);
    rd_chk("R12 control", 2'd2, 16'h0004);
    chk("R12 quiet", {wake_req, sci, smi}, 3'b000);
    pulse(10);
    chk("R12 wake req", wake_req, 1'b1);
    @(negedge clk);
    chk("R12 running", pwr_state, 2'd0);
    rd_chk("R12 wak set", 2'd0, 16'h8400);
    cleanup();
  endtask

  initial begin
    t_reset();
    t_w1c();
    t_unimpl();
    t_route();
    t_bit5_bit0();
    t_alarm_wake();
    t_pcie();
    t_core_reset();
    t_pf_policy0();
    t_pf_policy1();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule